// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block runs a 12-bit parallel sampling converter in its fully host-controlled mode. When the host asserts a request, the sequencer drives the active-low convert strobe low for a set number of clock cycles. It then waits for the converter's status pin to report the end of conversion. After that it drives chip-select and read low together for an access window, captures the two's-complement result, and offers it downstream on a valid/ready stream.

The sequencer enforces the converter's timing rules in system-clock cycles. These rules are:
- a minimum convert-strobe width;
- a minimum read-access time;
- a minimum track (acquisition) gap between the end of one conversion and the next start;
- a power-up settling interval.

A configuration pin selects how the status pin is read:
- **Interrupt convention:** the status pin falls when data is ready and rises after the read.
- **Busy convention:** the status pin is low while the converter works and rises when it is done.

A watchdog on the end-of-conversion wait raises a sticky error flag.

The output stream obeys the usual back-pressure rules. A word is offered with `out_valid` high and is transferred on a cycle where `out_ready` is also high. While `out_ready` is low, the word and `out_valid` hold unchanged, and no new conversion is started. Holding `out_ready` low therefore pauses sampling instead of dropping data.

Top module: `adc_rd_seq`

## Requirements
- R1: While `rst_n` is low and right after it, `adc_cnv_n`, `adc_cs_n` and `adc_rd_n` are high, `out_valid` is 0 and `timeout_err` is 0.
- R2: No convert strobe is issued until more than PWRUP_CYC clock cycles after reset is released, even if `req` is held high.
- R3: A conversion starts only while `req` is high, and every `adc_cnv_n` low pulse lasts exactly CNV_CYC cycles.
- R4: With `cfg_int_mode`=1, the end of conversion is a falling edge of the synchronized status pin.
- R5: With `cfg_int_mode`=0, the end of conversion is a rising edge of the synchronized status pin that follows a low level seen since the start; the high level present before the status pin first goes low is not taken as the end.
- R6: `adc_cs_n` and `adc_rd_n` go low together for exactly RD_CYC cycles, never while `adc_cnv_n` is low. The word is captured from `adc_data` at the clock edge that ends the window.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` stay unchanged. After a cycle with both high, `out_valid` is 0.
- R8: No convert strobe is issued while a word is waiting on the output.
- R9: A new convert strobe begins at least GAP_CYC cycles after the status-pin edge that ended the previous conversion.
- R10: With `cfg_int_mode`=1, no conversion starts until the synchronized status pin is back high.
- R11: If no end of conversion is detected within TMO_CYC cycles of the strobe's release, `timeout_err` rises exactly TMO_CYC cycles after that release. No word is emitted, the strobes stay high, and the sequencer accepts requests again. `timeout_err` stays 1 until reset.
- R12: The status pin passes through a two-flop synchronizer. The read strobes fall on the third rising clock edge after the status-pin edge that ends the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_int_mode | input | 1 | 1: interrupt status convention; 0: busy convention. Change only while idle |
| req | input | 1 | Level request: keep converting while high |
| adc_stat | input | 1 | Converter status pin, asynchronous |
| adc_data | input | DATA_W | Converter data bus, two's complement |
| adc_cnv_n | output | 1 | Convert-start strobe, active low |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | DATA_W | Captured conversion word |
| timeout_err | output | 1 | Sticky end-of-conversion timeout flag |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- **Status edges:** it counts the edges from each status-pin change to the read strobe, which exposes a missing synchronizer stage or a busy-mode design that takes the idle high level as completion.
- **Early sampling:** a converter model drives garbage until the access time has passed, so a design that samples one cycle early returns wrong words to the scoreboard.
- **Back-pressure:** it stalls the sink, and a design that restarts conversions or lets the word slip is caught.
- **Interrupt release:** it keeps the interrupt status low long after the read, which catches a design that starts a conversion before the status returns high.
- **Timeout:** a silent conversion checks both the timeout cycle count and that the error flag stays set.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_WAIT,
    S_READ,
    S_OUT,
    S_GAP
  } seq_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/adc_stat_sync.sv
// Multi-stage synchronizer for the converter status pin with edge detection
// on the synchronized copy. Resets to the idle-high level.
module adc_stat_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_in,
  output logic stat_s,
  output logic stat_rise,
  output logic stat_fall
);

  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '1;
    else        shreg <= {shreg[STAGES-1:0], stat_in};
  end

  assign stat_s    = shreg[STAGES-1];
  assign stat_rise = shreg[STAGES-1] & ~shreg[STAGES];
  assign stat_fall = ~shreg[STAGES-1] & shreg[STAGES];

endmodule

// File: rtl/adc_dcnt.sv
// Down counter that stops at zero; used for the power-up and track intervals.
module adc_dcnt #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= W'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/adc_eoc_detect.sv
// Selects the end-of-conversion event for the chosen status convention.
module adc_eoc_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic int_mode,
  input  logic armed,
  input  logic stat_s,
  input  logic stat_rise,
  input  logic stat_fall,
  output logic eoc
);

  logic seen_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                seen_low <= 1'b0;
    else if (!armed)           seen_low <= 1'b0;
    else if (!stat_s)          seen_low <= 1'b1;
  end

  assign eoc = int_mode ? stat_fall : (stat_rise & seen_low);

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CNV_CYC     = 6,
  parameter int RD_CYC      = 15,
  parameter int GAP_CYC     = 70,
  parameter int PWRUP_CYC   = 420,
  parameter int TMO_CYC     = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_int_mode,
  input  logic              req,
  input  logic              adc_stat,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_cnv_n,
  output logic              adc_cs_n,
  output logic              adc_rd_n,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              timeout_err
);

  localparam int PH_MAX = max3(CNV_CYC, RD_CYC, TMO_CYC);
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int GAP_W  = $clog2(GAP_CYC + 1);
  localparam int PWR_W  = $clog2(PWRUP_CYC + 1);

  seq_state_t        state;
  logic [PH_W-1:0]   ph;
  logic [DATA_W-1:0] word_q;
  logic              err_q;

  logic stat_s, stat_rise, stat_fall, eoc;
  logic pwr_done, gap_done, gap_load;

  adc_stat_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_in  (adc_stat),
    .stat_s   (stat_s),
    .stat_rise(stat_rise),
    .stat_fall(stat_fall)
  );

  adc_eoc_detect i_eoc (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_mode (cfg_int_mode),
    .armed    (state == S_START || state == S_WAIT),
    .stat_s   (stat_s),
    .stat_rise(stat_rise),
    .stat_fall(stat_fall),
    .eoc      (eoc)
  );

  adc_dcnt #(.W(PWR_W), .RST_VAL(PWRUP_CYC)) i_pwr_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (1'b0),
    .load_val('0),
    .done    (pwr_done)
  );

  assign gap_load = (state == S_WAIT) && eoc;

  adc_dcnt #(.W(GAP_W), .RST_VAL(0)) i_gap_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .load_val(GAP_W'(GAP_CYC)),
    .done    (gap_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ph     <= '0;
      word_q <= '0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          ph <= '0;
          if (pwr_done && gap_done && req && (!cfg_int_mode || stat_s))
            state <= S_START;
        end
        S_START: begin
          if (ph == PH_W'(CNV_CYC - 1)) begin
            state <= S_WAIT;
            ph    <= '0;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        S_WAIT: begin
          if (eoc) begin
            state <= S_READ;
            ph    <= '0;
          end else if (ph == PH_W'(TMO_CYC - 1)) begin
            state <= S_IDLE;
            ph    <= '0;
            err_q <= 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        S_READ: begin
          if (ph == PH_W'(RD_CYC - 1)) begin
            word_q <= adc_data;
            state  <= S_OUT;
            ph     <= '0;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        S_OUT: begin
          if (out_ready) state <= S_GAP;
        end
        S_GAP: begin
          if (gap_done) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign adc_cnv_n   = (state != S_START);
  assign adc_cs_n    = (state != S_READ);
  assign adc_rd_n    = (state != S_READ);
  assign out_valid   = (state == S_OUT);
  assign out_data    = word_q;
  assign timeout_err = err_q;

endmodule

// File: rtl/adc_rd_seq_chk.sv
module adc_rd_seq_chk #(
  parameter int DATA_W  = 12,
  parameter int CNV_CYC = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_int_mode,
  input logic              adc_cnv_n,
  input logic              adc_cs_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              timeout_err,
  input logic              stat_s,
  input logic              pwr_done
);

  int lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lo_cnt <= 0;
    else if (!adc_cnv_n) lo_cnt <= lo_cnt + 1;
    else                 lo_cnt <= 0;
  end

  // R2: power-up interval blocks the strobe
  p_pwrup_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_done |-> adc_cnv_n);

  // R3: strobe width in cycles
  p_cnv_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cnv_n) |-> lo_cnt == CNV_CYC);

  // R6: read never overlaps the convert strobe
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!adc_cnv_n && !adc_cs_n));

  // R7: word held under back-pressure
  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R7: valid drops after transfer
  p_valid_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid);

  // R8: no start while a word waits
  p_no_start_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> adc_cnv_n);

  // R10: interrupt status must be back high before a start
  p_int_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cnv_n) && cfg_int_mode |-> $past(stat_s));

  // R11: error flag is sticky
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);

endmodule

bind adc_rd_seq adc_rd_seq_chk #(.DATA_W(DATA_W), .CNV_CYC(CNV_CYC)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_int_mode(cfg_int_mode),
  .adc_cnv_n   (adc_cnv_n),
  .adc_cs_n    (adc_cs_n),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .timeout_err (timeout_err),
  .stat_s      (stat_s),
  .pwr_done    (pwr_done)
);

// File: tb/test_adc_rd_seq.sv
`timescale 1ns/1ps
module test_adc_rd_seq;

  localparam int DATA_W    = 12;
  localparam int CNV_CYC   = 6;
  localparam int RD_CYC    = 15;
  localparam int GAP_CYC   = 70;
  localparam int PWRUP_CYC = 420;
  localparam int TMO_CYC   = 1000;
  localparam int CONV_T    = 20;
  localparam logic [DATA_W-1:0] GARB = 12'hBAD;

  logic clk = 1'b0;
  logic rst_n, cfg_int_mode, req, adc_stat, out_ready;
  logic [DATA_W-1:0] adc_data;
  logic adc_cnv_n, adc_cs_n, adc_rd_n, out_valid, timeout_err;
  logic [DATA_W-1:0] out_data;

  adc_rd_seq #(
    .DATA_W(DATA_W), .CNV_CYC(CNV_CYC), .RD_CYC(RD_CYC), .GAP_CYC(GAP_CYC),
    .PWRUP_CYC(PWRUP_CYC), .TMO_CYC(TMO_CYC), .SYNC_STAGES(2)
  ) i_adc_rd_seq (
    .clk(clk), .rst_n(rst_n), .cfg_int_mode(cfg_int_mode), .req(req),
    .adc_stat(adc_stat), .adc_data(adc_data), .adc_cnv_n(adc_cnv_n),
    .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .timeout_err(timeout_err)
  );

  initial forever #2.5 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int cyc = 0, rel_cyc = 0;
  logic [DATA_W-1:0] exp_q[$];
  int starts = 0, words_done = 0;
  int eoc_cyc = 0, stat_rel_cyc = 0;
  bit eoc_any = 0, first_start = 1, done_flag = 0;
  int dead_cnt = 0, int_hold = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] word_for(input int i);
    case (i % 6)
      0: return 12'h7FF;
      1: return 12'h800;
      2: return 12'h000;
      3: return 12'hFFF;
      4: return 12'h123 + DATA_W'(i);
      default: return 12'h5A5 ^ DATA_W'(i);
    endcase
  endfunction

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // converter model: changes pins 1 ns after each rising edge
  initial begin
    int conv_idx, conv_left, acc, hold_left;
    bit in_conv, wait_read, releasing, cnv_prev;
    logic [DATA_W-1:0] cur_word;
    conv_idx = 0; conv_left = 0; acc = 0; hold_left = 0;
    in_conv = 0; wait_read = 0; releasing = 0; cnv_prev = 1;
    cur_word = '0;
    adc_stat = 1'b1;
    adc_data = GARB;
    forever begin
      @(posedge clk);
      #1;
      if (!adc_cnv_n && cnv_prev) begin
        starts++;
        if (dead_cnt > 0) dead_cnt--;
        else begin
          in_conv = 1; conv_left = CONV_T;
          cur_word = word_for(conv_idx); conv_idx++;
          exp_q.push_back(cur_word);
          if (!cfg_int_mode) adc_stat = 1'b0;
        end
      end else if (in_conv) begin
        conv_left--;
        if (conv_left == 0) begin
          in_conv = 0; eoc_cyc = cyc; eoc_any = 1;
          if (cfg_int_mode) begin adc_stat = 1'b0; wait_read = 1; end
          else adc_stat = 1'b1;
        end
      end
      cnv_prev = adc_cnv_n;
      if (!adc_cs_n && !adc_rd_n) acc++; else acc = 0;
      adc_data = (acc >= RD_CYC) ? cur_word : GARB;
      if (wait_read && acc > 0) begin
        wait_read = 0; releasing = 1; hold_left = int_hold;
      end
      if (releasing) begin
        if (hold_left == 0) begin adc_stat = 1'b1; stat_rel_cyc = cyc; releasing = 0; end
        else hold_left--;
      end
    end
  end

  // monitor and scoreboard: samples on falling edges
  initial begin
    logic cnv_p, cs_p, v_p, r_p, err_p;
    logic [DATA_W-1:0] d_p, exp_w;
    int lo_start, cs_start, cnv_rise_cyc;
    cnv_p = 1; cs_p = 1; v_p = 0; r_p = 0; err_p = 0; d_p = '0;
    lo_start = 0; cs_start = 0; cnv_rise_cyc = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!adc_cnv_n && cnv_p) begin
          lo_start = cyc;
          check(adc_cs_n == 1'b1, "R6 strobe overlap", adc_cs_n, 1);
          check(out_valid == 1'b0, "R8 start while word pending", out_valid, 0);
          if (eoc_any) check(cyc - eoc_cyc >= GAP_CYC, "R9 track gap", cyc - eoc_cyc, GAP_CYC);
          if (cfg_int_mode) begin
            check(adc_stat == 1'b1, "R10 status high at start", adc_stat, 1);
            check(cyc - stat_rel_cyc >= 2, "R10 start after release", cyc - stat_rel_cyc, 2);
          end
          if (first_start) begin
            first_start = 0;
            check(cyc - rel_cyc > PWRUP_CYC, "R2 power-up interval", cyc - rel_cyc, PWRUP_CYC + 1);
          end
        end
        if (adc_cnv_n && !cnv_p) begin
          check(cyc - lo_start == CNV_CYC, "R3 strobe width", cyc - lo_start, CNV_CYC);
          cnv_rise_cyc = cyc;
        end
        if (!adc_cs_n && cs_p) begin
          cs_start = cyc;
          check(adc_rd_n == 1'b0, "R6 rd with cs", adc_rd_n, 0);
          check(cyc - eoc_cyc == 3, cfg_int_mode ? "R12 R4 read after falling status" :
                "R12 R5 read after rising status", cyc - eoc_cyc, 3);
        end
        if (adc_cs_n && !cs_p)
          check(cyc - cs_start == RD_CYC, "R6 read window", cyc - cs_start, RD_CYC);
        if (v_p && !r_p)
          check(out_valid && out_data == d_p, "R7 hold under back-pressure", int'(out_data), int'(d_p));
        if (v_p && r_p)
          check(!out_valid, "R7 valid drop after transfer", out_valid, 0);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) check(0, "R6 unexpected word", int'(out_data), -1);
          else begin
            exp_w = exp_q.pop_front();
            check(out_data == exp_w, "R6 captured word", int'(out_data), int'(exp_w));
          end
          words_done++;
        end
        if (timeout_err && !err_p)
          check(cyc - cnv_rise_cyc == TMO_CYC, "R11 timeout delay", cyc - cnv_rise_cyc, TMO_CYC);
      end
      cnv_p = adc_cnv_n; cs_p = adc_cs_n; v_p = out_valid; r_p = out_ready;
      d_p = out_data; err_p = timeout_err;
    end
  end

  task automatic wait_words(input int n, input int limit);
    int target;
    target = words_done + n;
    for (int i = 0; i < limit && words_done < target; i++) @(posedge clk);
    check(words_done >= target, "R3 words delivered", words_done, target);
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      finish_test();
    end
  end

  initial begin
    int s0;
    rst_n = 1'b0; req = 1'b1; out_ready = 1'b1; cfg_int_mode = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check(adc_cnv_n && adc_cs_n && adc_rd_n, "R1 strobes idle in reset", {adc_cnv_n, adc_cs_n, adc_rd_n}, 7);
    check(!out_valid && !timeout_err, "R1 outputs cleared in reset", {out_valid, timeout_err}, 0);
    rst_n = 1'b1; rel_cyc = cyc;
    @(posedge clk); #1;
    check(adc_cnv_n && !out_valid, "R1 idle after reset", {adc_cnv_n, out_valid}, 2);

    // interrupt convention, free running
    wait_words(4, 2000);

    // back-pressure
    @(posedge clk); #1; out_ready = 1'b0;
    for (int i = 0; i < 2000 && !out_valid; i++) @(posedge clk);
    s0 = starts;
    repeat (150) @(posedge clk);
    #1;
    check(starts == s0, "R8 no start while stalled", starts, s0);
    check(out_valid == 1'b1, "R7 valid held while stalled", out_valid, 1);
    out_ready = 1'b1;
    wait_words(2, 2000);

    // interrupt status held low long after the read
    int_hold = 150;
    wait_words(2, 3000);
    int_hold = 0;

    // request low: no starts
    @(posedge clk); #1; req = 1'b0;
    repeat (200) @(posedge clk);
    s0 = starts;
    repeat (300) @(posedge clk);
    #1;
    check(starts == s0 && adc_cnv_n, "R3 no start without request", starts, s0);

    // busy convention
    cfg_int_mode = 1'b0;
    @(posedge clk); #1; req = 1'b1;
    wait_words(4, 2000);

    // timeout on a silent conversion
    dead_cnt = 1;
    for (int i = 0; i < 3000 && !timeout_err; i++) @(posedge clk);
    check(timeout_err == 1'b1, "R11 timeout flagged", timeout_err, 1);
    wait_words(3, 3000);
    #1;
    check(timeout_err == 1'b1, "R11 error stays set", timeout_err, 1);

    @(posedge clk); #1; req = 1'b0;
    repeat (300) @(posedge clk);
    check(exp_q.size() == 0, "R6 all words delivered", exp_q.size(), 0);
    done_flag = 1;
    finish_test();
  end

endmodule